// File: doc/BRIEF.md
# Serial Flash Row-Erase Sequencer

This block runs on the host side of a two-wire serial programming link, with one clock line and one data line, to a flash target. It erases the target one 64-byte row at a time, and each erase clears that row offset in every memory panel at once. Every transaction on the link is a frame: a 4-bit command code followed by a 16-bit payload. Both parts are sent least-significant bit first. The data line changes only on a rising edge of the serial clock, and the target samples it on the falling edge.

A single `start` pulse launches the whole job. The block first sends a fixed setup sequence. This sequence points the target's 24-bit table pointer at 3C0006h and writes 0040h there to enable erasing all panels together. It then restores code-memory access with writes enabled. After setup, the block repeats a seven-frame group once for each row:
- clear the upper pointer byte;
- load the high pointer byte;
- load the low pointer byte;
- send a start-programming table write;
- send a NOP frame whose fourth clock is stretched.

The stretched high phase of that fourth clock is the erase pulse, and its length is `p9Cycles`. The low phase that follows is the discharge time, and its length is `p10Cycles`. The row address starts at 0 and steps by 64 until it reaches the panel size given by `panelBytes`.

Top module: `rowEraseSeq`

## Requirements
- R1: After reset, `busy`, `done`, `pgcOut`, `pgdOut` are 0 and `rowAddr` is 0.
- R2: Each frame is 20 serial clock pulses. The first 4 carry the command code LSB first, and the next 16 carry the payload LSB first. `pgdOut` changes only in a cycle where `pgcOut` rises. Every high phase, and every low phase inside a frame, lasts HALF_CYCLES system clocks, except the two stretched phases of R5 and R6.
- R3: The run opens with exactly these 13 frames, in this order, as (command, payload):
  - (0000, 8EA6), (0000, 8CA6), (0000, 86A6);
  - (0000, 0E3C), (0000, 6EF8), (0000, 0E00), (0000, 6EF7), (0000, 0E06), (0000, 6EF6);
  - (1100, 0040);
  - (0000, 8EA6), (0000, 9CA6), (0000, 88A6).
- R4: Each row then gets exactly these 7 frames, where A is the row address:
  - (0000, 6AF8);
  - (0000, 0E & A[15:8]), (0000, 6EF7);
  - (0000, 0E & A[7:0]), (0000, 6EF6);
  - (1111, 0000);
  - (0000, 0000).
- R5: In the NOP frame of each row group, the 4th clock stays high for exactly `p9Cycles` system clocks. A value of 0 counts as 1.
- R6: The low phase after that stretched clock lasts exactly `p10Cycles` system clocks before the 5th clock rises. A value of 0 counts as 1.
- R7: Row addresses run 0, 64, 128, and so on. The number of rows is ceil(`panelBytes`/64), with a minimum of 1. After completion `rowAddr` holds the last row's address.
- R8: `busy` is 1 from the cycle after `start` until the last frame ends. Then `done` goes to 1 and stays there until the next `start`. The two are never high together.
- R9: A `start` pulse while `busy` is 1 has no effect on the frame stream.
- R10: The pointer bytes loaded in each row group equal `rowAddr` while that group's start-programming frame is shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches an erase run |
| panelBytes | input | ADDR_W+1 | Panel size in bytes (up to 65536) |
| p9Cycles | input | CNT_W | Erase pulse length in system clocks |
| p10Cycles | input | CNT_W | Discharge low time in system clocks |
| pgcOut | output | 1 | Serial programming clock |
| pgdOut | output | 1 | Serial programming data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| rowAddr | output | ADDR_W | Row offset being erased |

## Verification
Any fault in the step counter or the sequence table shows up within one frame, because it corrupts the command and payload bits that the bench's target model decodes at each falling clock edge. A wrong hold counter shows up as a clock phase of the wrong length, either in the NOP frame or in an ordinary frame. It is visible on the first erase group. A wrong address step or end test changes how many row groups are sent, or which pointer bytes they carry. That difference appears by the end of the run at the latest. A wrong final address is visible on `rowAddr` once `done` rises.

// File: rtl/rowErasePkg.sv
package rowErasePkg;
  localparam logic [3:0] CMD_CORE    = 4'b0000;
  localparam logic [3:0] CMD_TWRITE  = 4'b1100;
  localparam logic [3:0] CMD_TWSTART = 4'b1111;

  typedef struct packed {
    logic        load;
    logic        stretch;
    logic [3:0]  cmd;
    logic [15:0] payload;
    logic        clrAddr;
    logic        advAddr;
  } dpCtrl_t;
endpackage

// File: rtl/eraseDatapath.sv
module eraseDatapath
  import rowErasePkg::*;
#(
  parameter int HALF_CYCLES = 2,
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 24,
  parameter int ROW_BYTES   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [ADDR_W:0]   panelBytes,
  input  logic [CNT_W-1:0]  p9Cycles,
  input  logic [CNT_W-1:0]  p10Cycles,
  output logic              pgcOut,
  output logic              pgdOut,
  output logic              frameDone,
  output logic              lastRow,
  output logic [ADDR_W-1:0] rowAddr
);
  localparam int FRAME_BITS = 20;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] HOLD_BIT = BIT_W'(3);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] HALF     = CNT_W'(HALF_CYCLES);
  localparam logic [ADDR_W:0]  ROW_STEP = (ADDR_W + 1)'(ROW_BYTES);

  logic [FRAME_BITS-1:0] shReg;
  logic [BIT_W-1:0]      bitIdx;
  logic                  phaseHigh;
  logic                  active;
  logic                  stretchQ;
  logic [CNT_W-1:0]      cnt;
  logic [BIT_W-1:0]      nextIdx;

  function automatic logic [CNT_W-1:0] atLeastOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign nextIdx   = bitIdx + BIT_W'(1);
  assign frameDone = active && !phaseHigh && (cnt == CNT_W'(1)) && (bitIdx == LAST_BIT);
  assign lastRow   = ({1'b0, rowAddr} + ROW_STEP) >= panelBytes;

  // serial shifter and phase timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      bitIdx    <= '0;
      phaseHigh <= 1'b0;
      active    <= 1'b0;
      stretchQ  <= 1'b0;
      cnt       <= '0;
      pgcOut    <= 1'b0;
      pgdOut    <= 1'b0;
    end else if (ctl.load) begin
      shReg     <= {ctl.payload, ctl.cmd};
      bitIdx    <= '0;
      phaseHigh <= 1'b1;
      active    <= 1'b1;
      stretchQ  <= ctl.stretch;
      cnt       <= HALF;
      pgcOut    <= 1'b1;
      pgdOut    <= ctl.cmd[0];
    end else if (active) begin
      if (cnt == CNT_W'(1)) begin
        if (phaseHigh) begin
          phaseHigh <= 1'b0;
          pgcOut    <= 1'b0;
          cnt       <= (stretchQ && bitIdx == HOLD_BIT) ? atLeastOne(p10Cycles) : HALF;
        end else if (bitIdx == LAST_BIT) begin
          active <= 1'b0;
        end else begin
          bitIdx    <= nextIdx;
          phaseHigh <= 1'b1;
          pgcOut    <= 1'b1;
          pgdOut    <= shReg[1];
          shReg     <= {1'b0, shReg[FRAME_BITS-1:1]};
          cnt       <= (stretchQ && nextIdx == HOLD_BIT) ? atLeastOne(p9Cycles) : HALF;
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // row address register
  always_ff @(posedge clk) begin
    if (!rstN)            rowAddr <= '0;
    else if (ctl.clrAddr) rowAddr <= '0;
    else if (ctl.advAddr) rowAddr <= rowAddr + ADDR_W'(ROW_BYTES);
  end

  p_data_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pgdOut) |-> $rose(pgcOut));

  p_cnt_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (cnt != '0));

  p_idle_clock_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !pgcOut);

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rowAddr) |-> (rowAddr == '0 || rowAddr == $past(rowAddr) + ADDR_W'(ROW_BYTES)));
endmodule

// File: rtl/eraseCtrl.sv
module eraseCtrl
  import rowErasePkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              frameDone,
  input  logic              lastRow,
  input  logic [ADDR_W-1:0] rowAddr,
  output dpCtrl_t           ctl,
  output logic              busy,
  output logic              done
);
  localparam int SETUP_LEN = 13;
  localparam int GROUP_LEN = 7;
  localparam int STEP_W    = $clog2(SETUP_LEN + GROUP_LEN);
  localparam logic [STEP_W-1:0] LOOP_BASE = STEP_W'(SETUP_LEN);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SETUP_LEN + GROUP_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT} state_t;

  state_t            state;
  logic [STEP_W-1:0] step;
  logic [15:0]       ptr;
  logic [20:0]       entry;

  // {stretch, payload, cmd}
  function automatic logic [20:0] romEntry(input logic [STEP_W-1:0] s, input logic [15:0] a);
    case (s)
      STEP_W'(0):  romEntry = {1'b0, 16'h8EA6, CMD_CORE};
      STEP_W'(1):  romEntry = {1'b0, 16'h8CA6, CMD_CORE};
      STEP_W'(2):  romEntry = {1'b0, 16'h86A6, CMD_CORE};
      STEP_W'(3):  romEntry = {1'b0, 16'h0E3C, CMD_CORE};
      STEP_W'(4):  romEntry = {1'b0, 16'h6EF8, CMD_CORE};
      STEP_W'(5):  romEntry = {1'b0, 16'h0E00, CMD_CORE};
      STEP_W'(6):  romEntry = {1'b0, 16'h6EF7, CMD_CORE};
      STEP_W'(7):  romEntry = {1'b0, 16'h0E06, CMD_CORE};
      STEP_W'(8):  romEntry = {1'b0, 16'h6EF6, CMD_CORE};
      STEP_W'(9):  romEntry = {1'b0, 16'h0040, CMD_TWRITE};
      STEP_W'(10): romEntry = {1'b0, 16'h8EA6, CMD_CORE};
      STEP_W'(11): romEntry = {1'b0, 16'h9CA6, CMD_CORE};
      STEP_W'(12): romEntry = {1'b0, 16'h88A6, CMD_CORE};
      STEP_W'(13): romEntry = {1'b0, 16'h6AF8, CMD_CORE};
      STEP_W'(14): romEntry = {1'b0, 8'h0E, a[15:8], CMD_CORE};
      STEP_W'(15): romEntry = {1'b0, 16'h6EF7, CMD_CORE};
      STEP_W'(16): romEntry = {1'b0, 8'h0E, a[7:0], CMD_CORE};
      STEP_W'(17): romEntry = {1'b0, 16'h6EF6, CMD_CORE};
      STEP_W'(18): romEntry = {1'b0, 16'h0000, CMD_TWSTART};
      default:     romEntry = {1'b1, 16'h0000, CMD_CORE};
    endcase
  endfunction

  assign ptr   = 16'(rowAddr);
  assign entry = romEntry(step, ptr);
  assign busy  = (state != S_IDLE);

  always_comb begin
    ctl.load    = (state == S_LOAD);
    ctl.stretch = entry[20];
    ctl.payload = entry[19:4];
    ctl.cmd     = entry[3:0];
    ctl.clrAddr = (state == S_IDLE) && start;
    ctl.advAddr = (state == S_WAIT) && frameDone && (step == LAST_STEP) && !lastRow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_LOAD;
          step  <= '0;
          done  <= 1'b0;
        end
        S_LOAD: state <= S_WAIT;
        default: if (frameDone) begin
          if (step == LAST_STEP) begin
            if (lastRow) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              step  <= LOOP_BASE;
              state <= S_LOAD;
            end
          end else begin
            step  <= step + STEP_W'(1);
            state <= S_LOAD;
          end
        end
      endcase
    end
  end

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (step >= $past(step)) || (step == LOOP_BASE));

  p_single_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> !ctl.load);
endmodule

// File: rtl/rowEraseSeq.sv
module rowEraseSeq
  import rowErasePkg::*;
#(
  parameter int HALF_CYCLES = 2,
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 24,
  parameter int ROW_BYTES   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W:0]   panelBytes,
  input  logic [CNT_W-1:0]  p9Cycles,
  input  logic [CNT_W-1:0]  p10Cycles,
  output logic              pgcOut,
  output logic              pgdOut,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] rowAddr
);
  dpCtrl_t ctl;
  logic    frameDone;
  logic    lastRow;

  eraseCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .frameDone(frameDone),
    .lastRow(lastRow), .rowAddr(rowAddr), .ctl(ctl), .busy(busy), .done(done)
  );

  eraseDatapath #(
    .HALF_CYCLES(HALF_CYCLES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ROW_BYTES(ROW_BYTES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .panelBytes(panelBytes),
    .p9Cycles(p9Cycles), .p10Cycles(p10Cycles), .pgcOut(pgcOut), .pgdOut(pgdOut),
    .frameDone(frameDone), .lastRow(lastRow), .rowAddr(rowAddr)
  );
endmodule

// File: tb/test_rowEraseSeq.sv
module test_rowEraseSeq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int MAXF       = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [16:0] panelBytes = 17'd256;
  logic [23:0] p9Cycles = 24'd5;
  logic [23:0] p10Cycles = 24'd5;
  logic        pgcOut, pgdOut, busy, done;
  logic [15:0] rowAddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rowEraseSeq #(.HALF_CYCLES(HALF)) i_rowEraseSeq (
    .clk(clk), .rstN(rstN), .start(start), .panelBytes(panelBytes),
    .p9Cycles(p9Cycles), .p10Cycles(p10Cycles), .pgcOut(pgcOut), .pgdOut(pgdOut),
    .busy(busy), .done(done), .rowAddr(rowAddr)
  );

  // behavioural target model
  logic        monRst = 1'b1;
  int          nFr;
  logic [3:0]  frCmd [MAXF];
  logic [15:0] frPay [MAXF];
  int          frHi3 [MAXF];
  int          frLo3 [MAXF];
  bit          frOdd [MAXF];
  logic [15:0] frAddr[MAXF];
  int          bitCnt, hiCnt, loCnt, curHi3, curLo3;
  bit          curOdd, prevPgc, dataGlitch;
  logic [19:0] shIn;
  logic        prevPgd;

  always @(negedge clk) begin
    if (monRst) begin
      nFr = 0; bitCnt = 0; hiCnt = 0; loCnt = 0; curOdd = 0;
      curHi3 = 0; curLo3 = 0; prevPgc = 0; shIn = '0; dataGlitch = 0; prevPgd = pgdOut;
    end else begin
      if (pgdOut !== prevPgd && !(pgcOut && !prevPgc)) dataGlitch = 1;
      if (pgcOut && !prevPgc) begin
        if (bitCnt != 0) begin
          if (bitCnt - 1 == 3) curLo3 = loCnt;
          else if (loCnt != HALF) curOdd = 1;
        end
        hiCnt = 1;
      end else if (pgcOut) hiCnt++;
      if (!pgcOut && prevPgc) begin
        if (bitCnt == 3) curHi3 = hiCnt;
        else if (hiCnt != HALF) curOdd = 1;
        shIn = {pgdOut, shIn[19:1]};
        loCnt = 1;
        bitCnt++;
        if (bitCnt == 20) begin
          if (nFr < MAXF) begin
            frCmd[nFr] = shIn[3:0]; frPay[nFr] = shIn[19:4];
            frHi3[nFr] = curHi3; frLo3[nFr] = curLo3;
            frOdd[nFr] = curOdd; frAddr[nFr] = rowAddr;
          end
          nFr++; bitCnt = 0; curOdd = 0;
        end
      end else if (!pgcOut) loCnt++;
      prevPgc = pgcOut;
      prevPgd = pgdOut;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [19:0] expWord(input int k, input logic [15:0] a);
    logic [19:0] w;
    case (k)
      0: w = {16'h8EA6, 4'h0};  1: w = {16'h8CA6, 4'h0};  2: w = {16'h86A6, 4'h0};
      3: w = {16'h0E3C, 4'h0};  4: w = {16'h6EF8, 4'h0};  5: w = {16'h0E00, 4'h0};
      6: w = {16'h6EF7, 4'h0};  7: w = {16'h0E06, 4'h0};  8: w = {16'h6EF6, 4'h0};
      9: w = {16'h0040, 4'hC}; 10: w = {16'h8EA6, 4'h0}; 11: w = {16'h9CA6, 4'h0};
      12: w = {16'h88A6, 4'h0};
      default: case ((k - 13) % 7)
        0: w = {16'h6AF8, 4'h0};
        1: w = {8'h0E, a[15:8], 4'h0};
        2: w = {16'h6EF7, 4'h0};
        3: w = {8'h0E, a[7:0], 4'h0};
        4: w = {16'h6EF6, 4'h0};
        5: w = {16'h0000, 4'hF};
        default: w = {16'h0000, 4'h0};
      endcase
    endcase
    return w;
  endfunction

  task automatic runErase(input int panel, input int p9, input int p10, input bit poke, input string tag);
    int rows, expF, exp9, exp10, guard, firstBad;
    bit codesOk, holdOk, normOk, ptrOk;
    logic [15:0] a, ptrSeen;
    rows  = (panel <= 64) ? 1 : (panel + 63) / 64;
    expF  = 13 + 7 * rows;
    exp9  = (p9 == 0) ? 1 : p9;
    exp10 = (p10 == 0) ? 1 : p10;
    panelBytes = 17'(panel); p9Cycles = 24'(p9); p10Cycles = 24'(p10);
    @(negedge clk); monRst = 1'b1;
    @(negedge clk); monRst = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, {"R8 busy after start ", tag}, busy, 1);
    guard = 0;
    while (done !== 1'b1 && guard < 60000) begin
      @(negedge clk);
      guard++;
      if (poke && guard == 300) begin
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
    end
    check(done === 1'b1 && busy === 1'b0, {"R8 done level ", tag}, done, 1);
    check(nFr == expF, {"R7 R9 frame count ", tag}, nFr, expF);
    codesOk = 1; holdOk = 1; normOk = 1; ptrOk = 1; firstBad = -1; ptrSeen = '0;
    for (int k = 0; k < nFr && k < expF && k < MAXF; k++) begin
      a = (k < 13) ? 16'h0 : 16'(((k - 13) / 7) * 64);
      if ({frPay[k], frCmd[k]} !== expWord(k, a)) begin
        if (codesOk) firstBad = k;
        codesOk = 0;
      end
      if (frOdd[k]) normOk = 0;
      if (k >= 13 && (k - 13) % 7 == 6) begin
        if (frHi3[k] != exp9 || frLo3[k] != exp10) holdOk = 0;
      end else if (frHi3[k] != HALF || frLo3[k] != HALF) normOk = 0;
      if (k >= 13 && (k - 13) % 7 == 1) ptrSeen[15:8] = frPay[k][7:0];
      if (k >= 13 && (k - 13) % 7 == 3) ptrSeen[7:0]  = frPay[k][7:0];
      if (k >= 13 && (k - 13) % 7 == 5 && ptrSeen !== frAddr[k]) ptrOk = 0;
    end
    check(codesOk, {"R3 R4 frame codes ", tag}, firstBad, -1);
    check(holdOk, {"R5 R6 erase hold lengths ", tag}, frHi3[(expF - 1) % MAXF], exp9);
    check(normOk, {"R2 normal phase lengths ", tag}, normOk, 1);
    check(!dataGlitch, {"R2 data moves only at clock rise ", tag}, dataGlitch, 0);
    check(ptrOk, {"R10 pointer equals rowAddr ", tag}, ptrSeen, rowAddr);
    check(rowAddr == 16'((rows - 1) * 64), {"R7 final rowAddr ", tag}, rowAddr, (rows - 1) * 64);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done after reset", {busy, done}, 0);
    check(pgcOut === 1'b0 && pgdOut === 1'b0, "R1 serial lines after reset", {pgcOut, pgdOut}, 0);
    check(rowAddr === 16'h0, "R1 rowAddr after reset", rowAddr, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_fourRows();  runErase(256, 37, 11, 0, "four rows");  endtask
  task automatic t_partial();   runErase(100, 0, 0, 0, "partial row zero holds"); endtask
  task automatic t_tinyPanel(); runErase(0, 3, 7, 0, "empty panel");  endtask
  task automatic t_restart();   runErase(192, 120, 4, 1, "start while busy R9"); endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    t_reset();
    t_fourRows();
    t_partial();
    t_tinyPanel();
    t_restart();
    finish();
  end
endmodule